// File: doc/BRIEF.md
# Multi-Set Paged Address Translator

This block maps the first megabyte of host memory space into a 32 MB expanded-memory space. The megabyte is cut into 64 windows of 16 KB. The window number, held in CPU address bits 19 to 14, indexes a mapping table of 4096 sixteen-bit words. The table is organised as 64 banks of 64 words, and the bank is called a register set. For each memory access the selected word supplies an 11-bit page number. The block joins that page number with the 14-bit window offset to form a 25-bit expanded address. The same word carries a per-window decode flag, so software chooses which windows the card claims and no jumpers are needed.

Software programs the table through a small group of I/O ports and never maps the table into memory. It first writes a window index into an index latch. It then writes or reads a 16-bit word through the data port, and that access reaches the entry chosen by the index latch and the edit-set latch. A separate active-set latch selects the bank used for translation, so one bank can be edited while another bank is live. At reset the control word is cleared, so no window decodes and only the I/O ports respond.

The table has a single address path. During a data-port access the table address comes from the latches, and at all other times it comes from the CPU address lines. The decode hit is therefore held low while a data-port access is in progress.

Top module: `page_mapper`

## Requirements
- R1: After reset the index latch, the active-set latch, the edit-set latch and the control word all read back as 0. The hit output stays 0 for any CPU address while a memory cycle is signalled.
- R2: An I/O write to port 0 loads `io_wdata[5:0]` into the index latch. A read of port 0 returns that value zero-extended to 16 bits.
- R3: An I/O write to port 1 stores all 16 bits of `io_wdata` into the table entry at set = edit-set latch, window = index latch.
- R4: While `io_rd` is high with `io_port` = 1, `io_rdata` shows, in the same cycle, the 16-bit entry at set = edit-set latch, window = index latch.
- R5: An I/O write to port 2 loads the active-set latch from `io_wdata[5:0]`. An I/O write to port 3 loads the edit-set latch from `io_wdata[5:0]`. Each latch reads back zero-extended on its own port and keeps its value when its port is not written.
- R6: With no data-port access in progress, `ems_addr` is made combinationally, in the same cycle as `cpu_addr`. Its bits [24:14] are bits [10:0] of the entry at set = active-set latch, window = `cpu_addr[19:14]`, and its bits [13:0] equal `cpu_addr[13:0]`.
- R7: Port 4 is the control word, and bit 0 of it is the global decode enable. `hit` is 1 exactly when the enable is 1, bit 15 of the selected entry is 1, `mem_cycle` is 1, and no data-port access is in progress.
- R8: Writing an entry in a set other than the active set leaves the translated address and the hit of the active set unchanged.
- R9: I/O writes to ports 5, 6 and 7 change no latch, no control bit and no table entry. Reads of those ports return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_rd | input | 1 | I/O read strobe |
| io_port | input | 3 | I/O port offset (0 index, 1 data, 2 active set, 3 edit set, 4 control) |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 16 | I/O read data, combinational |
| mem_cycle | input | 1 | Memory cycle in progress |
| cpu_addr | input | 20 | CPU address within the first megabyte |
| ems_addr | output | 25 | Translated expanded-memory address |
| hit | output | 1 | Window decoded by this block |

## Verification
The assertions assume that `io_wr` and `io_rd` are never high together, and that the table is not read at an entry until that entry has been written once. The assertions also assume that the I/O strobes are stable around the clock edge. The bench drives each I/O strobe for exactly one cycle, away from the edge. It performs translations and data-port reads only at set/window pairs it has already written, and it tracks those pairs in a written-flag array. Random windows and sets come from a fixed seed, so every run replays the same access sequence.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
   localparam int PORT_W = 3;
   typedef enum logic [PORT_W-1:0] {
      PORT_INDEX = 3'd0,
      PORT_DATA  = 3'd1,
      PORT_ACT   = 3'd2,
      PORT_EDIT  = 3'd3,
      PORT_CTRL  = 3'd4
   } port_e;
endpackage

// File: rtl/pmap_regs.sv
module pmap_regs
   import pmap_pkg::*;
#(
   parameter int SLOT_W   = 6,
   parameter int SET_W    = 6,
   parameter int DATA_W   = 16,
   parameter int CTRL_W   = 1,
   parameter bit READBACK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  logic [PORT_W-1:0] io_port,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic [DATA_W-1:0] tbl_word,
   output logic [SLOT_W-1:0] slot_q,
   output logic [SET_W-1:0]  act_q,
   output logic [SET_W-1:0]  edit_q,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic [DATA_W-1:0] rdata
);
   if (SLOT_W > DATA_W || SET_W > DATA_W || CTRL_W > DATA_W) begin : g_chk_w
      $error("pmap_regs: latch wider than data port");
   end

   logic [DATA_W-1:0] data_view;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
         act_q  <= '0;
         edit_q <= '0;
         ctrl_q <= '0;
      end else if (io_wr) begin
         case (io_port)
            PORT_INDEX: slot_q <= io_wdata[SLOT_W-1:0];
            PORT_ACT:   act_q  <= io_wdata[SET_W-1:0];
            PORT_EDIT:  edit_q <= io_wdata[SET_W-1:0];
            PORT_CTRL:  ctrl_q <= io_wdata[CTRL_W-1:0];
            default: ;
         endcase
      end
   end

   if (READBACK) begin : g_rb
      assign data_view = tbl_word;
   end else begin : g_norb
      assign data_view = '0;
   end

   always_comb begin
      case (io_port)
         PORT_INDEX: rdata = DATA_W'(slot_q);
         PORT_DATA:  rdata = data_view;
         PORT_ACT:   rdata = DATA_W'(act_q);
         PORT_EDIT:  rdata = DATA_W'(edit_q);
         PORT_CTRL:  rdata = DATA_W'(ctrl_q);
         default:    rdata = '0;
      endcase
   end

   assert_index_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_port == PORT_INDEX) |=> slot_q == $past(io_wdata[SLOT_W-1:0]));
   assert_act_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_wr && io_port == PORT_ACT) |=> $stable(act_q));
   assert_edit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_wr && io_port == PORT_EDIT) |=> $stable(edit_q));
   assert_ctrl_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_port == PORT_CTRL) |=> ctrl_q == $past(io_wdata[CTRL_W-1:0]));
endmodule

// File: rtl/pmap_table.sv
module pmap_table #(
   parameter int SLOT_W = 6,
   parameter int SET_W  = 6,
   parameter int DATA_W = 16,
   localparam int IDX_W = SET_W + SLOT_W,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  edit_idx,
   input  logic [IDX_W-1:0]  xlat_idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_word
);
   if (DEPTH > 8192) begin : g_chk_depth
      $error("pmap_table: table depth too large");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [IDX_W-1:0]  addr;

   // single address path: latches during data-port access, CPU otherwise
   assign addr    = busy ? edit_idx : xlat_idx;
   assign rd_word = mem[addr];

   always_ff @(posedge clk) begin
      if (wr_en) mem[addr] <= wdata;
   end

   assert_entry_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> mem[$past(edit_idx)] == $past(wdata));
   assert_entry_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !$isunknown(rd_word)) |=> mem[$past(addr)] == $past(rd_word));
   assert_wr_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> busy);
endmodule

// File: rtl/pmap_xlate.sv
module pmap_xlate #(
   parameter int DATA_W  = 16,
   parameter int PAGE_W  = 11,
   parameter int OFF_W   = 14,
   parameter int DEC_BIT = 15,
   localparam int EMS_W  = PAGE_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] word,
   input  logic [OFF_W-1:0]  cpu_off,
   input  logic              dec_en,
   input  logic              mem_cycle,
   input  logic              busy,
   output logic [EMS_W-1:0]  ems_addr,
   output logic              hit
);
   if (DEC_BIT < PAGE_W || DEC_BIT >= DATA_W) begin : g_chk_dec
      $error("pmap_xlate: decode flag overlaps page field or exceeds word");
   end

   assign ems_addr = {word[PAGE_W-1:0], cpu_off};
   assign hit      = dec_en & word[DEC_BIT] & mem_cycle & ~busy;

   assert_hit_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (dec_en && mem_cycle && !busy));
   assert_offset_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ems_addr[OFF_W-1:0] == cpu_off);
endmodule

// File: rtl/page_mapper.sv
module page_mapper
   import pmap_pkg::*;
#(
   parameter int SLOT_W   = 6,
   parameter int SET_W    = 6,
   parameter int PAGE_W   = 11,
   parameter int OFF_W    = 14,
   parameter int DATA_W   = 16,
   parameter int DEC_BIT  = 15,
   parameter int CTRL_W   = 1,
   parameter bit READBACK = 1'b1,
   localparam int CPU_W   = SLOT_W + OFF_W,
   localparam int EMS_W   = PAGE_W + OFF_W,
   localparam int IDX_W   = SET_W + SLOT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [PORT_W-1:0] io_port,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   input  logic              mem_cycle,
   input  logic [CPU_W-1:0]  cpu_addr,
   output logic [EMS_W-1:0]  ems_addr,
   output logic              hit
);
   if (PAGE_W >= DATA_W) begin : g_chk_page
      $error("page_mapper: no spare bit left for the decode flag");
   end

   logic [SLOT_W-1:0] slot_q;
   logic [SET_W-1:0]  act_q, edit_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic [DATA_W-1:0] tbl_word;
   logic              busy, tbl_wr;

   assign busy   = (io_wr | io_rd) & (io_port == PORT_DATA);
   assign tbl_wr = io_wr & (io_port == PORT_DATA);

   pmap_regs #(
      .SLOT_W(SLOT_W), .SET_W(SET_W), .DATA_W(DATA_W),
      .CTRL_W(CTRL_W), .READBACK(READBACK)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_port(io_port),
      .io_wdata(io_wdata), .tbl_word(tbl_word), .slot_q(slot_q),
      .act_q(act_q), .edit_q(edit_q), .ctrl_q(ctrl_q), .rdata(io_rdata)
   );

   pmap_table #(
      .SLOT_W(SLOT_W), .SET_W(SET_W), .DATA_W(DATA_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n), .busy(busy), .wr_en(tbl_wr),
      .edit_idx({edit_q, slot_q}),
      .xlat_idx({act_q, cpu_addr[CPU_W-1:OFF_W]}),
      .wdata(io_wdata), .rd_word(tbl_word)
   );

   pmap_xlate #(
      .DATA_W(DATA_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W), .DEC_BIT(DEC_BIT)
   ) u_xlate (
      .clk(clk), .rst_n(rst_n), .word(tbl_word),
      .cpu_off(cpu_addr[OFF_W-1:0]), .dec_en(ctrl_q[0]),
      .mem_cycle(mem_cycle), .busy(busy), .ems_addr(ems_addr), .hit(hit)
   );

   assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_wr && io_rd));
   assert_no_hit_io_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !hit);
endmodule

// File: tb/sim_page_mapper.sv
module sim_page_mapper;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_wr = 1'b0, io_rd = 1'b0;
   logic [2:0]  io_port = 3'd0;
   logic [15:0] io_wdata = 16'd0;
   logic [15:0] io_rdata;
   logic        mem_cycle = 1'b0;
   logic [19:0] cpu_addr = 20'd0;
   logic [24:0] ems_addr;
   logic        hit;

   int tests = 0, fails = 0;
   logic [15:0] model [4096];
   bit          written [4096];
   int          wlist [$];
   logic [5:0]  m_slot = 0, m_act = 0, m_edit = 0;
   logic        m_en = 0;

   always #2 clk = ~clk;

   page_mapper u0 (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
      .io_port(io_port), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .mem_cycle(mem_cycle), .cpu_addr(cpu_addr), .ems_addr(ems_addr),
      .hit(hit)
   );

   function automatic logic [24:0] exp_ems(logic [15:0] w, logic [19:0] a);
      return {w[10:0], a[13:0]};
   endfunction

   function automatic logic exp_hit(logic en, logic [15:0] w, logic mc);
      return en & w[15] & mc;
   endfunction

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic io_write(logic [2:0] p, logic [15:0] d);
      @(negedge clk);
      io_port = p; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
      case (p)
         3'd0: m_slot = d[5:0];
         3'd1: begin
            model[{m_edit, m_slot}] = d;
            if (!written[{m_edit, m_slot}]) wlist.push_back(int'({m_edit, m_slot}));
            written[{m_edit, m_slot}] = 1'b1;
         end
         3'd2: m_act = d[5:0];
         3'd3: m_edit = d[5:0];
         3'd4: m_en = d[0];
         default: ;
      endcase
   endtask

   task automatic io_read(logic [2:0] p, output logic [15:0] d, output logic h);
      @(negedge clk);
      io_port = p; io_rd = 1'b1;
      #1;
      d = io_rdata; h = hit;
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic xlate(logic [19:0] a, logic mc, string req);
      logic [15:0] w;
      @(negedge clk);
      cpu_addr = a; mem_cycle = mc;
      #1;
      w = model[{m_act, a[19:14]}];
      check(req, {7'd0, ems_addr}, {7'd0, exp_ems(w, a)});
      check(req, {31'd0, hit}, {31'd0, exp_hit(m_en, w, mc)});
   endtask

   initial begin
      #(4 * 200000);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [15:0] d;
      logic        h;
      void'($urandom(32'd1234));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int p = 0; p < 5; p++) begin
         io_read(3'(p), d, h);
         if (p != 1) check("R1 reset latch", {16'd0, d}, 32'd0);
      end
      @(negedge clk);
      mem_cycle = 1'b1; cpu_addr = 20'hA1234;
      #1 check("R1 no hit after reset", {31'd0, hit}, 32'd0);
      mem_cycle = 1'b0;

      // R2 index latch
      io_write(3'd0, 16'hFFC5);
      io_read(3'd0, d, h);
      check("R2 index readback", {16'd0, d}, 32'h05);

      // R5 edit/active sets
      io_write(3'd3, 16'h0003);
      io_read(3'd3, d, h);
      check("R5 edit readback", {16'd0, d}, 32'h3);
      io_write(3'd1, 16'h8123);               // R3
      io_read(3'd1, d, h);
      check("R4 data readback", {16'd0, d}, 32'h8123);
      io_write(3'd2, 16'h0043);
      io_read(3'd2, d, h);
      check("R5 active readback", {16'd0, d}, 32'h3);

      // R6/R7 translation, enable off then on
      xlate({6'd5, 14'h1ABC}, 1'b1, "R6 xlate enable off");
      io_write(3'd4, 16'h0001);
      io_read(3'd4, d, h);
      check("R7 ctrl readback", {16'd0, d}, 32'h1);
      xlate({6'd5, 14'h1ABC}, 1'b1, "R7 hit on");
      check("R7 hit value", {31'd0, hit}, 32'd1);
      xlate({6'd5, 14'h0000}, 1'b0, "R7 no memory cycle");

      // R7 busy: data-port read suppresses hit
      @(negedge clk);
      cpu_addr = {6'd5, 14'h0010}; mem_cycle = 1'b1;
      io_port = 3'd1; io_rd = 1'b1;
      #1 check("R7 hit low during table access", {31'd0, hit}, 32'd0);
      @(negedge clk);
      io_rd = 1'b0; mem_cycle = 1'b0;

      // R8 edit another set, active unchanged
      io_write(3'd3, 16'h0007);
      io_write(3'd1, 16'h0055);
      xlate({6'd5, 14'h2222}, 1'b1, "R8 other set untouched");
      io_write(3'd1, 16'h0155);
      io_read(3'd1, d, h);
      check("R4 readback set 7", {16'd0, d}, 32'h0155);

      // R9 unused ports
      for (int p = 5; p < 8; p++) begin
         io_write(3'(p), 16'hFFFF);
         io_read(3'(p), d, h);
         check("R9 unused port reads 0", {16'd0, d}, 32'd0);
      end
      io_read(3'd0, d, h);
      check("R9 index untouched", {16'd0, d}, {26'd0, m_slot});
      io_read(3'd2, d, h);
      check("R9 active untouched", {16'd0, d}, {26'd0, m_act});
      io_read(3'd3, d, h);
      check("R9 edit untouched", {16'd0, d}, {26'd0, m_edit});
      io_read(3'd4, d, h);
      check("R9 ctrl untouched", {16'd0, d}, {31'd0, m_en});
      io_read(3'd1, d, h);
      check("R9 entry untouched", {16'd0, d}, {16'd0, model[{m_edit, m_slot}]});

      // random programming and translation
      for (int i = 0; i < 300; i++) begin
         int k = int'($urandom_range(0, 3));
         if (k == 0 || wlist.size() == 0) begin
            io_write(3'd3, 16'($urandom_range(0, 63)));
            io_write(3'd0, 16'($urandom_range(0, 63)));
            io_write(3'd1, 16'($urandom));
            io_read(3'd1, d, h);
            check("R4 random readback", {16'd0, d}, {16'd0, model[{m_edit, m_slot}]});
         end else if (k == 1) begin
            io_write(3'd4, 16'($urandom_range(0, 1)));
         end else begin
            int idx = wlist[$urandom_range(0, wlist.size() - 1)];
            logic [11:0] ix = 12'(idx);
            if (m_act != ix[11:6]) io_write(3'd2, {10'd0, ix[11:6]});
            xlate({ix[5:0], 14'($urandom)}, 1'($urandom), "R6 random xlate");
         end
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule